// File: doc/BRIEF.md
# Branch Condition Evaluator with Programmable Indirect Test

This block decides whether a conditional instruction executes. Each cycle it reads a small condition selector from the instruction and the current arithmetic status (zero, negative, overflow, carry, multiplier overflow, shifter overflow, ALU sign) plus a bank of general flag inputs. It drives one combinational `cond_true` bit that the sequencer uses to gate a branch, call or conditional compute.

Most tests have a selector value of their own. Tests with no selector value are reached indirectly. Software writes a code into a small internal code register. Two selector values then test the condition that register names, either as it is or inverted. This covers the shifter overflow, the ALU sign and any flag pin.

The code register is two stages deep, so a written code takes effect one cycle late. The instruction right after the write still sees the old code, and software pads that slot. Code values with no meaning make the indirect test false, and its inverse true.

Top module: `cond_eval`

## Requirements
- R1: Selector 0 is true when `st_zero` is 1; selector 1 is true when `st_zero` is 0.
- R2: Selector 2 is true when both `st_zero` and `st_neg` are 0; selector 3 is the complement of selector 2.
- R3: Selector 4 is true when `st_neg` is 1; selector 5 is true when `st_neg` is 0.
- R4: Selector 6 follows `st_ovf` and selector 7 its inverse; selector 8 follows `st_carry` and selector 9 its inverse.
- R5: Selector 12 follows `st_mulovf` and selector 13 its inverse; selector 14 is always true and selector 15 is always false.
- R6: Selector 10 is true when the condition named by the active code is true; selector 11 is the exact complement of selector 10 for every code.
- R7: Active code 0x09 makes the indirect test follow `st_shovf`; code 0x08 makes it follow the inverse of `st_shovf`.
- R8: Active code 0x04 makes the indirect test follow `st_sign`; code 0x05 makes it follow the inverse of `st_sign`.
- R9: Active code 0x03 makes the indirect test follow `flag_in[0]`; code 0x10+i, for i below NFLAG, follows `flag_in[i]`.
- R10: Any other code value, including the reset value 0x00, makes selector 10 false and selector 11 true.
- R11: A code written with `code_we` high in cycle t governs selectors 10 and 11 from cycle t+2 on. In cycle t and cycle t+1 the previous code still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the code register to 0x00 |
| cond_sel | input | 4 | Condition selector from the instruction |
| st_zero | input | 1 | Result-is-zero status |
| st_neg | input | 1 | Result-is-negative status |
| st_ovf | input | 1 | Arithmetic overflow status |
| st_carry | input | 1 | Carry status |
| st_mulovf | input | 1 | Multiplier overflow status |
| st_shovf | input | 1 | Shifter overflow status |
| st_sign | input | 1 | ALU input sign status |
| flag_in | input | NFLAG | General flag inputs |
| code_we | input | 1 | Code register write strobe |
| code_wdata | input | CODE_W | Code value to write |
| cond_true | output | 1 | Condition result, combinational from inputs and active code |

## Verification
The bench first targets the write lag. A code written while the indirect selector is in use must leave the result unchanged for that cycle and the next. A register only one stage deep would switch a cycle early and fail there. Undefined codes, including code 0x14 just past the last flag, must drive the indirect test false and its inverse true. A decoder that treated out-of-range flag codes as valid, or inverted an invalid test, would report the opposite value. The bench also checks that the greater-than test stays false when zero and negative are both set, which catches a design that tests only one of the two flags.

// File: rtl/cond_eval.sv
module cond_eval #(
  parameter int NFLAG = 4,
  parameter int CODE_W = 5,
  parameter logic [CODE_W-1:0] CODE_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cond_sel,
  input  logic              st_zero,
  input  logic              st_neg,
  input  logic              st_ovf,
  input  logic              st_carry,
  input  logic              st_mulovf,
  input  logic              st_shovf,
  input  logic              st_sign,
  input  logic [NFLAG-1:0]  flag_in,
  input  logic              code_we,
  input  logic [CODE_W-1:0] code_wdata,
  output logic              cond_true
);

  localparam logic [CODE_W-1:0] C_FLAG0 = CODE_W'(3);
  localparam logic [CODE_W-1:0] C_SIGN  = CODE_W'(4);
  localparam logic [CODE_W-1:0] C_NSIGN = CODE_W'(5);
  localparam logic [CODE_W-1:0] C_NSV   = CODE_W'(8);
  localparam logic [CODE_W-1:0] C_SV    = CODE_W'(9);
  localparam int FLAG_BASE = 16;

  localparam logic [3:0] S_EQ = 4'd0, S_NE = 4'd1, S_GT = 4'd2, S_LE = 4'd3;
  localparam logic [3:0] S_LT = 4'd4, S_GE = 4'd5, S_AV = 4'd6, S_NAV = 4'd7;
  localparam logic [3:0] S_AC = 4'd8, S_NAC = 4'd9, S_SW = 4'd10, S_NSW = 4'd11;
  localparam logic [3:0] S_MV = 4'd12, S_NMV = 4'd13, S_TRUE = 4'd14;

  logic [CODE_W-1:0] code_q, code_act;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      code_q   <= CODE_RST;
      code_act <= CODE_RST;
    end else begin
      if (code_we) code_q <= code_wdata;
      code_act <= code_q;
    end

  logic [NFLAG-1:0] flag_sel, flag_hit;
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign flag_sel[i] = (code_act == CODE_W'(FLAG_BASE + i));
    assign flag_hit[i] = flag_sel[i] & flag_in[i];
  end

  logic sw_ok, sw_val, sw_true;
  always_comb begin
    sw_ok  = 1'b1;
    sw_val = 1'b0;
    case (code_act)
      C_FLAG0: sw_val = flag_in[0];
      C_SIGN:  sw_val = st_sign;
      C_NSIGN: sw_val = !st_sign;
      C_SV:    sw_val = st_shovf;
      C_NSV:   sw_val = !st_shovf;
      default: begin
        sw_ok  = |flag_sel;
        sw_val = |flag_hit;
      end
    endcase
  end
  assign sw_true = sw_ok & sw_val;

  wire gt = !st_zero && !st_neg;

  always_comb begin
    case (cond_sel)
      S_EQ:    cond_true = st_zero;
      S_NE:    cond_true = !st_zero;
      S_GT:    cond_true = gt;
      S_LE:    cond_true = !gt;
      S_LT:    cond_true = st_neg;
      S_GE:    cond_true = !st_neg;
      S_AV:    cond_true = st_ovf;
      S_NAV:   cond_true = !st_ovf;
      S_AC:    cond_true = st_carry;
      S_NAC:   cond_true = !st_carry;
      S_SW:    cond_true = sw_true;
      S_NSW:   cond_true = !sw_true;
      S_MV:    cond_true = st_mulovf;
      S_NMV:   cond_true = !st_mulovf;
      S_TRUE:  cond_true = 1'b1;
      default: cond_true = 1'b0;
    endcase
  end

  p_gt_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == S_GT && (st_zero || st_neg)) |-> !cond_true);

  p_ne_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == S_NE) |-> (cond_true != st_zero));

  p_sv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == S_SW && code_act == C_SV) |-> (cond_true == st_shovf));

  p_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == S_NSW && code_act == C_SIGN) |-> (cond_true == !st_sign));

  p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(code_we, 2) |-> (code_act == $past(code_wdata, 2)));

  p_no_early_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (code_we && !$past(code_we)) |=> $stable(code_act));

  p_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 4'd15) |-> !cond_true);

endmodule

// File: tb/test_cond_eval.sv
module test_cond_eval;
  localparam int CLK_PERIOD = 10;
  localparam int NFLAG = 4;
  localparam int CODE_W = 5;

  logic clk = 0, rst_n = 0;
  logic [3:0] cond_sel = 0;
  logic st_zero = 0, st_neg = 0, st_ovf = 0, st_carry = 0;
  logic st_mulovf = 0, st_shovf = 0, st_sign = 0;
  logic [NFLAG-1:0] flag_in = 0;
  logic code_we = 0;
  logic [CODE_W-1:0] code_wdata = 0;
  logic cond_true;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [CODE_W-1:0] m_pend, m_act;

  cond_eval #(.NFLAG(NFLAG), .CODE_W(CODE_W)) i_cond_eval (
    .clk(clk), .rst_n(rst_n), .cond_sel(cond_sel),
    .st_zero(st_zero), .st_neg(st_neg), .st_ovf(st_ovf), .st_carry(st_carry),
    .st_mulovf(st_mulovf), .st_shovf(st_shovf), .st_sign(st_sign),
    .flag_in(flag_in), .code_we(code_we), .code_wdata(code_wdata),
    .cond_true(cond_true));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin m_pend <= '0; m_act <= '0; end
    else begin
      if (code_we) m_pend <= code_wdata;
      m_act <= m_pend;
    end

  function automatic logic exp_sw(input logic [CODE_W-1:0] c);
    case (c)
      5'h03: return flag_in[0];
      5'h04: return st_sign;
      5'h05: return !st_sign;
      5'h08: return !st_shovf;
      5'h09: return st_shovf;
      5'h10: return flag_in[0];
      5'h11: return flag_in[1];
      5'h12: return flag_in[2];
      5'h13: return flag_in[3];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic exp_cond(input logic [3:0] s, input logic [CODE_W-1:0] c);
    case (s)
      0: return st_zero;          1: return !st_zero;
      2: return !st_zero && !st_neg; 3: return st_zero || st_neg;
      4: return st_neg;           5: return !st_neg;
      6: return st_ovf;           7: return !st_ovf;
      8: return st_carry;         9: return !st_carry;
      10: return exp_sw(c);       11: return !exp_sw(c);
      12: return st_mulovf;       13: return !st_mulovf;
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] s, input logic [CODE_W-1:0] c);
    if (s <= 1) return "R1";
    if (s <= 3) return "R2";
    if (s <= 5) return "R3";
    if (s <= 9) return "R4";
    if (s == 10 || s == 11) begin
      case (c)
        5'h08, 5'h09: return "R7";
        5'h04, 5'h05: return "R8";
        5'h03, 5'h10, 5'h11, 5'h12, 5'h13: return "R9";
        default: return "R10";
      endcase
    end
    return "R5";
  endfunction

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (cond_true !== exp) begin
      errors++;
      $display("FAIL %s: cond_true=%0b expected=%0b (sel=%0d code=%0h)",
               tag, cond_true, exp, cond_sel, m_act);
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    summary();
  end

  initial begin
    logic [CODE_W-1:0] pool [12] = '{5'h03, 5'h04, 5'h05, 5'h08, 5'h09, 5'h10,
                                     5'h11, 5'h12, 5'h13, 5'h14, 5'h00, 5'h1f};
    void'($urandom(32'd20417));
    // reset state: code 0x00 is undefined (R10)
    #(CLK_PERIOD * 2 + 1);
    cond_sel = 4'd11; #1; chk(1'b1, "R10");
    cond_sel = 4'd10; #1; chk(1'b0, "R10");
    st_zero = 1; cond_sel = 4'd0; #1; chk(1'b1, "R1");
    @(negedge clk); rst_n = 1;

    // R2: both zero and negative set
    @(negedge clk); st_zero = 1; st_neg = 1; cond_sel = 4'd2; #1; chk(1'b0, "R2");
    cond_sel = 4'd3; #1; chk(1'b1, "R2");
    st_zero = 0; st_neg = 0; cond_sel = 4'd2; #1; chk(1'b1, "R2");

    // R11: write lag with shifter overflow code
    @(negedge clk); st_shovf = 1; cond_sel = 4'd10; code_we = 1; code_wdata = 5'h09;
    #1; chk(1'b0, "R11");
    @(negedge clk); code_we = 0; #1; chk(1'b0, "R11");
    @(negedge clk); #1; chk(1'b1, "R11");
    st_shovf = 0; #1; chk(1'b0, "R7");
    cond_sel = 4'd11; #1; chk(1'b1, "R6");

    // R10: code just past the last flag
    @(negedge clk); code_we = 1; code_wdata = 5'h14; flag_in = '1;
    @(negedge clk); code_we = 0;
    @(negedge clk); cond_sel = 4'd10; #1; chk(1'b0, "R10");
    cond_sel = 4'd11; #1; chk(1'b1, "R10");

    // R9: top flag through its code
    @(negedge clk); code_we = 1; code_wdata = 5'h13; flag_in = 4'b1000;
    @(negedge clk); code_we = 0;
    @(negedge clk); cond_sel = 4'd10; #1; chk(1'b1, "R9");
    flag_in = 4'b0111; #1; chk(1'b0, "R9");

    // back-to-back writes: second lands one cycle after first
    @(negedge clk); code_we = 1; code_wdata = 5'h04; st_sign = 1;
    @(negedge clk); code_wdata = 5'h05;
    @(negedge clk); code_we = 0; #1; chk(1'b1, "R11");
    @(negedge clk); #1; chk(1'b0, "R11");

    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      {st_zero, st_neg, st_ovf, st_carry, st_mulovf, st_shovf, st_sign} = 7'($urandom);
      flag_in = NFLAG'($urandom);
      cond_sel = ($urandom_range(0, 2) == 0) ? 4'($urandom_range(10, 11)) : 4'($urandom);
      code_we = ($urandom_range(0, 5) == 0);
      code_wdata = pool[$urandom_range(0, 11)];
      #1; chk(exp_cond(cond_sel, m_act), tag_of(cond_sel, m_act));
    end
    summary();
  end
endmodule